// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interpreter

This block is a synchronous behavioural model of the control logic inside a byte-wide parallel NOR flash. A system clock samples three active-low strobes (chip enable, output enable, write enable), a 19-bit address and an 8-bit input data bus. Bus writes are formed from the strobes and fed to a command sequencer. The sequencer only accepts program, erase and identification commands after a two-write unlock prefix.

Program and erase run for a parameterised number of clocks. During that time reads return polling status instead of array data, and all writes are dropped. The storage array is a folded window of synthesizable flip-flops. Sector index bits `addr[13:12]` and offset bits `addr[7:0]` form the array index. All other address bits alias.

Top module: `nfc_top`

## Requirements
- R1: A bus write exists only while `ce_n` and `we_n` are both low. Its address is sampled in the first clock where both are low, and its data in the last such clock. A pulse during which `oe_n` was low in any clock is discarded.
- R2: A low pulse of fewer than `MIN_PULSE` (default 2) clocks is discarded and does not advance or abort any sequence.
- R3: Each command begins with data AAh at address 5555h, then 55h at 2AAAh. Only `addr[14:0]` is compared.
- R4: After the prefix, A0h at 5555h makes the next write a program. The array byte at index `{addr[13:12],addr[7:0]}` becomes old AND new.
- R5: After the prefix, 80h at 5555h, and a second prefix, 30h at any address sets every byte of the sector selected by `addr[13:12]` to FFh. Other sectors are unchanged.
- R6: In the same six-write form, 10h at 5555h sets the whole array to FFh.
- R7: A write that does not match the expected step returns the block to read mode and leaves ID mode. The array is unchanged, and a later correct command works.
- R8: While a program or erase is running, every write is ignored.
- R9: While busy, a read returns bit 7 = complement of the programmed bit 7 (program) or 0 (erase), and bits 5..0 = 0. Bit 6 is 1 on the first read and inverts on each further read.
- R10: A program lasts `T_PROG+2` clocks from the sequencer entering busy. Sector and chip erase use `T_SECT` and `T_CHIP` in the same way. After that, reads return true array data.
- R11: After the prefix, 90h at 5555h enters ID mode. Reads at address 0 return BFh, at address 1 return B7h, and at any other address return 00h. A single F0h write to any address, or the prefix followed by F0h at 5555h, returns to array reads.
- R12: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low. `dq_out` is 00h whenever `dq_oe` is low.
- R13: After reset the block is in read mode with every array byte FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data or polling status |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench targets the following corner cases:
- **Staggered strobes.** The address and data change inside one write pulse. A design that latched at the wrong end would program the wrong byte or value.
- **Short pulses and inhibited writes.** One-clock glitches are placed inside a program sequence, and a write is issued with output enable low. A design without the filter or inhibit would program the glitch target or accept the unlock.
- **Writes during busy.** A complete program sequence is issued while an erase is running. A design that did not drop it would leave the other sector altered.
- **Polling status.** DQ7 and DQ6 are checked on consecutive busy reads. A wrong toggle phase or a leak of array data shows as a mismatch.
- **ID mode exit.** Both exit forms are used, and aborts are tried at several steps.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int AW       = 19;
    localparam int DW       = 8;
    localparam int KEY_W    = 15;
    localparam int SECT_LSB = 12;

    localparam logic [KEY_W-1:0] ADR_A = 15'h5555;
    localparam logic [KEY_W-1:0] ADR_B = 15'h2AAA;

    localparam logic [DW-1:0] K_UNLK1 = 8'hAA;
    localparam logic [DW-1:0] K_UNLK2 = 8'h55;
    localparam logic [DW-1:0] C_PROG  = 8'hA0;
    localparam logic [DW-1:0] C_ERASE = 8'h80;
    localparam logic [DW-1:0] C_IDIN  = 8'h90;
    localparam logic [DW-1:0] C_IDOUT = 8'hF0;
    localparam logic [DW-1:0] C_SECT  = 8'h30;
    localparam logic [DW-1:0] C_CHIP  = 8'h10;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;

    typedef enum logic [2:0] {
        ST_READ, ST_K1, ST_K2, ST_PDATA, ST_E0, ST_E1, ST_E2, ST_BUSY
    } step_e;

    typedef struct packed {
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
    } bus_wr_t;

    // unlock/command match: low address bits and data only
    function automatic logic key_hit(input bus_wr_t w, input logic [KEY_W-1:0] ka,
                                     input logic [DW-1:0] kd);
        return (w.adr[KEY_W-1:0] == ka) && (w.dat == kd);
    endfunction
endpackage

// File: rtl/nfc_wstrobe.sv
module nfc_wstrobe
    import nfc_pkg::*;
#(
    parameter int MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] dat,
    output logic          ev_vld,
    output bus_wr_t       ev
);
    localparam int CW = $clog2(MIN_PULSE + 1) < 1 ? 1 : $clog2(MIN_PULSE + 1);

    logic          low_now;
    logic          act_q;
    logic          spoil_q;
    logic [CW-1:0] cnt_q;
    bus_wr_t       cap_q;

    assign low_now = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            spoil_q <= 1'b0;
            cnt_q   <= '0;
            cap_q   <= '0;
            ev_vld  <= 1'b0;
            ev      <= '0;
        end else begin
            ev_vld <= 1'b0;
            if (low_now) begin
                if (!act_q) begin
                    cap_q.adr <= adr;           // later falling strobe
                    cnt_q     <= CW'(1);
                    spoil_q   <= !oe_n;
                end else begin
                    if (cnt_q < CW'(MIN_PULSE)) cnt_q <= cnt_q + CW'(1);
                    spoil_q <= spoil_q || !oe_n;
                end
                cap_q.dat <= dat;               // last low clock wins
                act_q     <= 1'b1;
            end else if (act_q) begin
                act_q  <= 1'b0;
                ev_vld <= !spoil_q && (cnt_q >= CW'(MIN_PULSE));
                ev     <= cap_q;
            end
        end
    end

    p_evt_after_release_r1: assert property (@(posedge clk) disable iff (rst)
        ev_vld |-> $past(ce_n || we_n));
    p_evt_no_oe_r1: assert property (@(posedge clk) disable iff (rst)
        ev_vld |-> !$past(spoil_q));
    p_evt_min_width_r2: assert property (@(posedge clk) disable iff (rst)
        ev_vld |-> ($past(cnt_q) >= CW'(MIN_PULSE)));
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ev_vld,
    input  bus_wr_t ev,
    input  logic    done,
    output step_e   step,
    output op_e     op,
    output logic    id_mode,
    output logic    start,
    output bus_wr_t tgt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= ST_READ;
            op      <= OP_NONE;
            id_mode <= 1'b0;
            start   <= 1'b0;
            tgt     <= '0;
        end else begin
            start <= 1'b0;
            if (step == ST_BUSY) begin
                if (done) begin
                    step <= ST_READ;
                    op   <= OP_NONE;
                end
            end else if (ev_vld) begin
                step <= ST_READ;                    // default: abort
                unique case (step)
                    ST_READ: begin
                        if (key_hit(ev, ADR_A, K_UNLK1)) step <= ST_K1;
                        else id_mode <= 1'b0;
                    end
                    ST_K1: begin
                        if (key_hit(ev, ADR_B, K_UNLK2)) step <= ST_K2;
                        else id_mode <= 1'b0;
                    end
                    ST_K2: begin
                        id_mode <= 1'b0;
                        if (ev.adr[KEY_W-1:0] == ADR_A) begin
                            if (ev.dat == C_PROG)       step <= ST_PDATA;
                            else if (ev.dat == C_ERASE) step <= ST_E0;
                            else if (ev.dat == C_IDIN)  id_mode <= 1'b1;
                        end
                    end
                    ST_PDATA: begin
                        tgt   <= ev;
                        op    <= OP_PROG;
                        start <= 1'b1;
                        step  <= ST_BUSY;
                    end
                    ST_E0: if (key_hit(ev, ADR_A, K_UNLK1)) step <= ST_E1;
                    ST_E1: if (key_hit(ev, ADR_B, K_UNLK2)) step <= ST_E2;
                    ST_E2: begin
                        if (ev.dat == C_SECT) begin
                            tgt   <= ev;
                            op    <= OP_SECT;
                            start <= 1'b1;
                            step  <= ST_BUSY;
                        end else if (key_hit(ev, ADR_A, C_CHIP)) begin
                            tgt   <= ev;
                            op    <= OP_CHIP;
                            start <= 1'b1;
                            step  <= ST_BUSY;
                        end
                    end
                    default: step <= ST_READ;
                endcase
            end
        end
    end

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BUSY && !done) |=> (step == ST_BUSY && $stable(tgt) && $stable(op)));
    p_start_op_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> (step == ST_BUSY && op != OP_NONE));
    p_id_clear_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BUSY) |-> !id_mode);
endmodule

// File: rtl/nfc_timer.sv
module nfc_timer
    import nfc_pkg::*;
#(
    parameter int T_PROG = 24,
    parameter int T_SECT = 64,
    parameter int T_CHIP = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  op,
    output logic done
);
    localparam int TM1  = (T_PROG > T_SECT) ? T_PROG : T_SECT;
    localparam int TMAX = (TM1 > T_CHIP) ? TM1 : T_CHIP;
    localparam int TW   = $clog2(TMAX + 1);

    logic [TW-1:0] cnt_q;

    function automatic logic [TW-1:0] dur(input op_e o);
        case (o)
            OP_SECT: return TW'(T_SECT);
            OP_CHIP: return TW'(T_CHIP);
            default: return TW'(T_PROG);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt_q <= dur(op);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - TW'(1);
                if (cnt_q == TW'(1)) done <= 1'b1;
            end
        end
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q != '0));
endmodule

// File: rtl/nfc_top.sv
module nfc_top
    import nfc_pkg::*;
#(
    parameter int          OFF_W     = 8,
    parameter int          SEC_W     = 2,
    parameter int          MIN_PULSE = 2,
    parameter int          T_PROG    = 24,
    parameter int          T_SECT    = 64,
    parameter int          T_CHIP    = 96,
    parameter logic [7:0]  MFR_ID    = 8'hBF,
    parameter logic [7:0]  DEV_ID    = 8'hB7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    localparam int IDX_W = OFF_W + SEC_W;
    localparam int DEPTH = 1 << IDX_W;

    function automatic logic [IDX_W-1:0] fold(input logic [AW-1:0] a);
        return {a[SECT_LSB +: SEC_W], a[OFF_W-1:0]};
    endfunction

    logic    ev_vld;
    bus_wr_t ev;
    step_e   step;
    op_e     op;
    logic    id_mode;
    logic    start;
    bus_wr_t tgt;
    logic    done;
    logic    rd_now;
    logic    rd_q;
    logic    tog_q;
    logic    unused_tgt;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_word;

    nfc_wstrobe #(.MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .adr(addr), .dat(dq_in), .ev_vld(ev_vld), .ev(ev)
    );

    nfc_seq u_seq (
        .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev(ev), .done(done),
        .step(step), .op(op), .id_mode(id_mode), .start(start), .tgt(tgt)
    );

    nfc_timer #(.T_PROG(T_PROG), .T_SECT(T_SECT), .T_CHIP(T_CHIP)) u_timer (
        .clk(clk), .rst(rst), .start(start), .op(op), .done(done)
    );

    assign unused_tgt = ^tgt.adr;

    // array commit at the end of the internal write
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (done) begin
            case (op)
                OP_PROG: mem_q[fold(tgt.adr)] <= mem_q[fold(tgt.adr)] & tgt.dat;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++)
                        if ((i >> OFF_W) == int'(tgt.adr[SECT_LSB +: SEC_W])) mem_q[i] <= '1;
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
                end
                default: ;
            endcase
        end
    end

    // toggle bit: 1 on first busy read, flips at the end of each read
    assign rd_now = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b1;
        end else begin
            rd_q <= rd_now;
            if (step != ST_BUSY) tog_q <= 1'b1;
            else if (rd_q && !rd_now) tog_q <= !tog_q;
        end
    end

    always_comb begin
        rd_word = mem_q[fold(addr)];
        if (step == ST_BUSY)
            rd_word = {(op == OP_PROG) ? !tgt.dat[7] : 1'b0, tog_q, 6'b0};
        else if (id_mode)
            rd_word = (addr[AW-1:1] == '0) ? (addr[0] ? DEV_ID : MFR_ID) : 8'h00;
    end

    assign dq_oe  = rd_now;
    assign dq_out = dq_oe ? rd_word : '0;

    p_float_r12: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (dq_out == '0));
    p_erase_dq7_r9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BUSY && op != OP_PROG && dq_oe) |-> !dq_out[7]);
    p_status_low_r9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BUSY && dq_oe) |-> (dq_out[5:0] == '0));
    p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_BUSY && rd_q && !rd_now) |=> (tog_q != $past(tog_q)));
endmodule

// File: tb/sim_nfc_top.sv
module sim_nfc_top;
    localparam int CLK_PERIOD = 10;
    localparam int TP = 24;
    localparam int TS = 64;
    localparam int TC = 96;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [1024];
    logic [7:0] rv;
    logic       exp_tog;

    always #(CLK_PERIOD/2) clk = !clk;

    nfc_top #(.T_PROG(TP), .T_SECT(TS), .T_CHIP(TC)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic int fidx(input logic [18:0] a);
        return int'({a[13:12], a[7:0]});
    endfunction

    function automatic logic [7:0] stat(input logic prog, input logic [7:0] d, input logic t);
        return {prog ? !d[7] : 1'b0, t, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d,
                             input int len, input logic oe_lvl);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl;
        repeat (len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        bus_write(a, d, 3, 1'b1);
    endtask

    task automatic bus_read(input logic [18:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dq_out;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [18:0] hi(input logic [14:0] lo);
        return {4'($urandom()), lo};
    endfunction

    task automatic cmd3(input logic [7:0] c);
        wr(hi(15'h5555), 8'hAA);
        wr(hi(15'h2AAA), 8'h55);
        wr(hi(15'h5555), c);
    endtask

    task automatic erase_pre();
        cmd3(8'h80);
        wr(hi(15'h5555), 8'hAA);
        wr(hi(15'h2AAA), 8'h55);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        cmd3(8'hA0);
        wr(a, d);
        model[fidx(a)] = model[fidx(a)] & d;
    endtask

    task automatic read_chk(input string req, input logic [18:0] a);
        logic [7:0] v;
        bus_read(a, v);
        chk(req, v, model[fidx(a)]);
    endtask

    task automatic busy_read(input string req, input logic p, input logic [7:0] d);
        logic [7:0] v;
        bus_read(19'h0, v);
        chk(req, v, stat(p, d, exp_tog));
        exp_tog = !exp_tog;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 / R13 reset state
        chk("R12 idle dq_oe", {7'b0, dq_oe}, 8'h00);
        chk("R12 idle dq_out", dq_out, 8'h00);
        read_chk("R13 erased after reset", 19'h00010);
        read_chk("R13 erased after reset", 19'h3A0FF);
        @(negedge clk); addr = 19'h00010; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R12 driven on read", {7'b0, dq_oe}, 8'h01);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk("R12 released after read", {7'b0, dq_oe}, 8'h00);

        // R4 / R9 / R10 program with status polling
        prog(19'h00042, 8'h5A);
        exp_tog = 1'b1;
        busy_read("R9 program status first", 1'b1, 8'h5A);
        busy_read("R9 program status second", 1'b1, 8'h5A);
        busy_read("R9 program status third", 1'b1, 8'h5A);
        repeat (TP - 14) @(negedge clk);
        busy_read("R10 still busy before expiry", 1'b1, 8'h5A);
        repeat (10) @(negedge clk);
        read_chk("R10 true data after program", 19'h00042);
        prog(19'h00042, 8'h0F);
        repeat (TP + 6) @(negedge clk);
        read_chk("R4 program is AND of old and new", 19'h00042);
        prog(19'h02080, 8'h3C);
        repeat (TP + 6) @(negedge clk);
        prog(19'h01081, 8'h77);
        repeat (TP + 6) @(negedge clk);

        // R5 / R8 / R9 sector erase with ignored writes during busy
        erase_pre();
        wr(19'h41123, 8'h30);
        for (int i = 0; i < 1024; i++) if ((i >> 8) == 1) model[i] = 8'hFF;
        exp_tog = 1'b1;
        busy_read("R9 erase status first", 1'b0, 8'h00);
        busy_read("R9 erase status second", 1'b0, 8'h00);
        cmd3(8'hA0);
        wr(19'h02080, 8'h00);
        repeat (TS + 6) @(negedge clk);
        read_chk("R5 selected sector erased", 19'h01081);
        read_chk("R5 other sector kept", 19'h00042);
        read_chk("R8 write during erase ignored", 19'h02080);

        // R7 aborts
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h77);
        wr(19'h00042, 8'h00);
        read_chk("R7 bad command aborts", 19'h00042);
        wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0);
        wr(19'h00042, 8'h00);
        read_chk("R7 bad unlock address aborts", 19'h00042);
        erase_pre();
        wr(19'h05555, 8'h55);
        wr(19'h00042, 8'h00);
        read_chk("R7 bad erase final aborts", 19'h00042);
        prog(19'h00043, 8'hC3);
        repeat (TP + 6) @(negedge clk);
        read_chk("R7 command works after abort", 19'h00043);

        // R2 glitch inside program sequence
        cmd3(8'hA0);
        bus_write(19'h00050, 8'h00, 1, 1'b1);
        wr(19'h00051, 8'h3C);
        model[fidx(19'h00051)] = 8'h3C;
        repeat (TP + 6) @(negedge clk);
        read_chk("R2 glitch target untouched", 19'h00050);
        read_chk("R2 real write programmed", 19'h00051);

        // R1 output enable low inhibits the unlock write
        bus_write(19'h05555, 8'hAA, 3, 1'b0);
        wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        wr(19'h00060, 8'h00);
        repeat (TP + 6) @(negedge clk);
        read_chk("R1 oe low inhibits write", 19'h00060);

        // R1 staggered strobes: address at later fall, data at earlier rise
        cmd3(8'hA0);
        @(negedge clk); addr = 19'h00070; we_n = 1'b0; dq_in = 8'h00;
        @(negedge clk); addr = 19'h00071; ce_n = 1'b0; dq_in = 8'h11;
        @(negedge clk); addr = 19'h00072; dq_in = 8'h22;
        @(negedge clk); dq_in = 8'h33;
        @(negedge clk); ce_n = 1'b1; dq_in = 8'h44;
        @(negedge clk); we_n = 1'b1;
        repeat (TP + 8) @(negedge clk);
        model[fidx(19'h00071)] = 8'h33;
        read_chk("R1 later-fall address and last data", 19'h00071);
        read_chk("R1 first address untouched", 19'h00070);
        read_chk("R1 changed address untouched", 19'h00072);

        // R11 ID mode, both exits
        cmd3(8'h90);
        bus_read(19'h00000, rv); chk("R11 manufacturer code", rv, 8'hBF);
        bus_read(19'h00001, rv); chk("R11 device code", rv, 8'hB7);
        bus_read(19'h00002, rv); chk("R11 other address", rv, 8'h00);
        wr(19'h1234F, 8'hF0);
        read_chk("R11 single exit restores reads", 19'h00043);
        cmd3(8'h90);
        bus_read(19'h00001, rv); chk("R11 device code again", rv, 8'hB7);
        cmd3(8'hF0);
        read_chk("R11 three-cycle exit restores reads", 19'h00043);

        // R3 / R4 / R5 constrained random, upper unlock bits random
        for (int k = 0; k < 40; k++) begin
            logic [18:0] a;
            a = 19'($urandom());
            if (k % 10 == 9) begin
                logic [1:0] s;
                s = 2'($urandom());
                erase_pre();
                wr({a[18:14], s, a[11:0]}, 8'h30);
                for (int i = 0; i < 1024; i++) if ((i >> 8) == int'(s)) model[i] = 8'hFF;
                repeat (TS + 6) @(negedge clk);
            end else begin
                prog(a, 8'($urandom()));
                repeat (TP + 6) @(negedge clk);
                read_chk("R3 R4 random program", a);
            end
            read_chk("R5 random readback", 19'($urandom()));
        end

        // R6 chip erase
        erase_pre();
        wr(19'h05555, 8'h10);
        exp_tog = 1'b1;
        busy_read("R9 chip erase status", 1'b0, 8'h00);
        for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
        repeat (TC + 6) @(negedge clk);
        read_chk("R6 chip erased", 19'h00043);
        read_chk("R6 chip erased", 19'h00071);
        read_chk("R6 chip erased", 19'h033FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule